// File: doc/BRIEF.md
# I2C Data Register with Access-Triggered Byte Transfer

This block is the host-visible byte register of an I2C controller together with the shift engine behind it. Host accesses to the register start bus activity. When the controller is bus master and set to transmit, a host write loads the byte and starts sending it. When set to receive, a host read returns the current register contents and starts receiving the next byte. When the controller is not master, the same two triggers work only while an external address comparator reports that this device has been addressed. Start and stop conditions, arbitration and input filtering belong to neighbouring blocks.

The bus side is a bit-level open-drain interface. The inputs are the sensed SCL and SDA line levels. The outputs are pull-low enables. Both sensed lines pass through a two-stage synchronizer, and the byte engine acts on the detected SCL edges. In master mode a small clock generator drives SCL. It holds the line low between bytes and makes nine pulses per byte. The high phase is timed only while the line is actually high, so a slave can stretch the clock. In slave mode SCL is released and the remote master supplies the clock.

The byte engine is a six-state machine:
- `SH_IDLE`: waits for a start pulse, then goes to `SH_SETUP`.
- `SH_SETUP`: waits for SCL low and places the first bit, then goes to `SH_HIGH`.
- `SH_HIGH`: on an SCL rise it samples the incoming bit, then goes to `SH_LOW`.
- `SH_LOW`: on an SCL fall it moves to the next bit (back to `SH_HIGH`), or after the eighth bit places the acknowledge and goes to `SH_ACK_HIGH`.
- `SH_ACK_HIGH`: on an SCL rise it samples the acknowledge, then goes to `SH_ACK_LOW`.
- `SH_ACK_LOW`: on an SCL fall it releases SDA, pulses done and returns to `SH_IDLE`.

The clock generator has two phases. `CG_LOW` goes to `CG_HIGH` once its low count expires. `CG_HIGH` goes back to `CG_LOW` once the line has been seen high for its full count.

Top module: `i2c_dtr_trigger`

## Requirements
- R1: After reset the data register reads 0x00, busy and byte_done are 0, and both scl_low and sda_low are 0 (lines released).
- R2: With mode_master=1 and mode_tx=1, a host write while busy=0 loads host_wdata into the register and starts a byte transmit. busy reads 1 after the clock edge that sampled the write.
- R3: Transmitted data appears on SDA most significant bit first. sda_low changes only while the synchronized SCL level is low.
- R4: With mode_master=1 and mode_tx=0, a host read while idle returns the register and starts a receive. When the byte completes, the register holds the eight bits sampled on SCL rises, the first sampled bit in bit 7.
- R5: If mode_tx is 1 when the register is read, the read returns the register and starts nothing: busy stays 0 and SCL gets no pulse.
- R6: With mode_master=0, an access starts a transfer only while addr_hit=1. With addr_hit=0 a write leaves busy at 0 and SDA released through nine remote clock pulses. With addr_hit=1 a write sends the byte under the remote clock.
- R7: In a receive, during the ninth SCL pulse SDA is pulled low when ack_ctl=0 (ACK) and left released when ack_ctl=1 (NACK).
- R8: In a transmit, ack_rx takes the SDA level sampled at the ninth SCL rise (0 = acknowledged, 1 = not acknowledged).
- R9: busy stays 1 from the triggering access until the cycle after byte_done. Accesses made while busy is 1, including one in the byte_done cycle, are ignored: the register is unchanged and no new transfer starts.
- R10: byte_done is a one-cycle pulse, given exactly once per byte after the ninth SCL fall.
- R11: In master mode the block holds SCL low while idle and makes exactly nine SCL pulses per byte. With mode_master=0 it releases SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe to the data register |
| host_rd | input | 1 | Host read strobe of the data register |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Current data register contents |
| mode_master | input | 1 | 1 = bus master, 0 = slave |
| mode_tx | input | 1 | 1 = transmit, 0 = receive |
| addr_hit | input | 1 | Slave has been addressed (level) |
| ack_ctl | input | 1 | Acknowledge to send for received bytes: 0 ACK, 1 NACK |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_low | output | 1 | Pull SCL low |
| sda_low | output | 1 | Pull SDA low |
| busy | output | 1 | Byte transfer in progress |
| byte_done | output | 1 | One-cycle pulse at end of byte plus acknowledge |
| ack_rx | output | 1 | Acknowledge level seen after last transmitted byte |

## Verification
Two functions can meet in one cycle: the end of a byte (byte_done with busy still high) and a new host access that would otherwise start the next byte. The bench waits until it sees byte_done high away from the clock edge and drives a host write in that same cycle. It then checks that the register keeps the earlier byte, that busy does not rise again and that SCL stays parked low. A second write placed in the middle of a byte is judged the same way, by comparing the byte captured on the wire with the byte first written.

// File: rtl/i2c_dtr_pkg.sv
package i2c_dtr_pkg;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_SETUP,
        SH_HIGH,
        SH_LOW,
        SH_ACK_HIGH,
        SH_ACK_LOW
    } shift_state_t;

    typedef enum logic {
        CG_LOW,
        CG_HIGH
    } clk_phase_t;

endpackage

// File: rtl/i2c_dtr_edge.sv
module i2c_dtr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall
);

    logic scl_s1, scl_s2, scl_d;
    logic sda_s1, sda_s2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_s1 <= 1'b1;
            scl_s2 <= 1'b1;
            scl_d  <= 1'b1;
            sda_s1 <= 1'b1;
            sda_s2 <= 1'b1;
        end else begin
            scl_s1 <= scl_i;
            scl_s2 <= scl_s1;
            scl_d  <= scl_s2;
            sda_s1 <= sda_i;
            sda_s2 <= sda_s1;
        end
    end

    assign scl_lvl  = scl_s2;
    assign sda_lvl  = sda_s2;
    assign scl_rise = scl_s2 & ~scl_d;
    assign scl_fall = ~scl_s2 & scl_d;

endmodule

// File: rtl/i2c_dtr_clkgen.sv
module i2c_dtr_clkgen
    import i2c_dtr_pkg::*;
#(
    parameter int SCL_HALF = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master,
    input  logic run,
    input  logic scl_lvl,
    output logic scl_low
);

    localparam int CW = $clog2(SCL_HALF + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(SCL_HALF - 1);

    clk_phase_t phase, phase_nx;
    logic [CW-1:0] cnt;
    logic expire;

    assign expire = (cnt == CNT_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= CG_LOW;
        else        phase <= phase_nx;
    end

    // next phase
    always_comb begin
        phase_nx = phase;
        if (!master || !run) begin
            phase_nx = CG_LOW;
        end else begin
            unique case (phase)
                CG_LOW:  if (expire)           phase_nx = CG_HIGH;
                CG_HIGH: if (expire && scl_lvl) phase_nx = CG_LOW;
                default: phase_nx = CG_LOW;
            endcase
        end
    end

    // outputs and counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            scl_low <= 1'b0;
        end else if (!master) begin
            cnt     <= '0;
            scl_low <= 1'b0;
        end else if (!run) begin
            cnt     <= '0;
            scl_low <= 1'b1;
        end else begin
            unique case (phase)
                CG_LOW: begin
                    if (expire) begin
                        cnt     <= '0;
                        scl_low <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                CG_HIGH: begin
                    if (scl_lvl) begin
                        if (expire) begin
                            cnt     <= '0;
                            scl_low <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    AST_SLAVE_RELEASES_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        !master |=> !scl_low);                          // R11
    AST_IDLE_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        (master && !run) |=> scl_low);                  // R11

endmodule

// File: rtl/i2c_dtr_shifter.sv
module i2c_dtr_shifter
    import i2c_dtr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_tx,
    input  logic [DW-1:0] tx_byte,
    input  logic          ack_ctl,
    input  logic          scl_lvl,
    input  logic          sda_lvl,
    input  logic          scl_rise,
    input  logic          scl_fall,
    output logic          sda_low,
    output logic          byte_done,
    output logic [DW-1:0] rx_byte,
    output logic          xfer_tx,
    output logic          ack_rx
);

    localparam int BW = (DW > 2) ? $clog2(DW) : 1;
    localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

    shift_state_t state, state_nx;
    logic [DW-1:0] shreg;
    logic [BW-1:0] bitcnt;
    logic          last_bit;

    assign last_bit = (bitcnt == BIT_LAST);
    assign rx_byte  = shreg;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SH_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            SH_IDLE:     if (start)    state_nx = SH_SETUP;
            SH_SETUP:    if (!scl_lvl) state_nx = SH_HIGH;
            SH_HIGH:     if (scl_rise) state_nx = SH_LOW;
            SH_LOW:      if (scl_fall) state_nx = last_bit ? SH_ACK_HIGH : SH_HIGH;
            SH_ACK_HIGH: if (scl_rise) state_nx = SH_ACK_LOW;
            SH_ACK_LOW:  if (scl_fall) state_nx = SH_IDLE;
            default:     state_nx = SH_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bitcnt    <= '0;
            xfer_tx   <= 1'b0;
            sda_low   <= 1'b0;
            byte_done <= 1'b0;
            ack_rx    <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            unique case (state)
                SH_IDLE: begin
                    if (start) begin
                        shreg   <= tx_byte;
                        xfer_tx <= start_tx;
                        bitcnt  <= '0;
                        sda_low <= 1'b0;
                    end
                end
                SH_SETUP: begin
                    if (!scl_lvl) sda_low <= xfer_tx & ~shreg[DW-1];
                end
                SH_HIGH: begin
                    if (scl_rise && !xfer_tx) shreg <= {shreg[DW-2:0], sda_lvl};
                end
                SH_LOW: begin
                    if (scl_fall) begin
                        if (last_bit) begin
                            sda_low <= ~xfer_tx & ~ack_ctl;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                            if (xfer_tx) begin
                                shreg   <= {shreg[DW-2:0], 1'b0};
                                sda_low <= ~shreg[DW-2];
                            end
                        end
                    end
                end
                SH_ACK_HIGH: begin
                    if (scl_rise && xfer_tx) ack_rx <= sda_lvl;
                end
                SH_ACK_LOW: begin
                    if (scl_fall) begin
                        sda_low   <= 1'b0;
                        byte_done <= 1'b1;
                    end
                end
                default: sda_low <= 1'b0;
            endcase
        end
    end

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low) |-> !$past(scl_lvl));         // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);                      // R10
    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state == SH_IDLE));                  // R9

endmodule

// File: rtl/i2c_dtr_trigger.sv
module i2c_dtr_trigger #(
    parameter int DW       = 8,
    parameter int SCL_HALF = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          mode_master,
    input  logic          mode_tx,
    input  logic          addr_hit,
    input  logic          ack_ctl,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          scl_low,
    output logic          sda_low,
    output logic          busy,
    output logic          byte_done,
    output logic          ack_rx
);

    logic          scl_lvl, sda_lvl, scl_rise, scl_fall;
    logic          enabled, tx_go, rx_go, start;
    logic          xfer_tx;
    logic [DW-1:0] data_reg, rx_byte;

    assign enabled = mode_master | addr_hit;
    assign tx_go   = host_wr & ~busy & enabled & mode_tx;
    assign rx_go   = host_rd & ~busy & enabled & ~mode_tx;
    assign start   = tx_go | rx_go;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_reg <= '0;
            busy     <= 1'b0;
        end else begin
            if (host_wr && !busy)
                data_reg <= host_wdata;
            else if (byte_done && !xfer_tx)
                data_reg <= rx_byte;

            if (start)          busy <= 1'b1;
            else if (byte_done) busy <= 1'b0;
        end
    end

    assign host_rdata = data_reg;

    i2c_dtr_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    i2c_dtr_clkgen #(.SCL_HALF(SCL_HALF)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .master  (mode_master),
        .run     (busy),
        .scl_lvl (scl_lvl),
        .scl_low (scl_low)
    );

    i2c_dtr_shifter #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_tx  (mode_tx),
        .tx_byte   (host_wdata),
        .ack_ctl   (ack_ctl),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_low   (sda_low),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .xfer_tx   (xfer_tx),
        .ack_rx    (ack_rx)
    );

    AST_BUSY_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(host_wr | host_rd));       // R2
    AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !busy);                            // R9
    AST_UNADDRESSED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_master && !addr_hit && !busy) |=> !busy); // R6

endmodule

// File: tb/sim_i2c_dtr_trigger.sv
module sim_i2c_dtr_trigger;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic mode_master = 1'b0, mode_tx = 1'b0, addr_hit = 1'b0, ack_ctl = 1'b0;
    logic scl_low, sda_low, busy, byte_done, ack_rx;
    logic tb_scl_low = 1'b0, tb_sda_low = 1'b0;
    logic scl_line, sda_line;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int pulse_cnt = 0;

    always #10 clk = ~clk;   // 50 MHz

    assign scl_line = ~(scl_low | tb_scl_low);
    assign sda_line = ~(sda_low | tb_sda_low);

    always @(posedge clk) if (byte_done) done_cnt++;
    always @(posedge scl_line) pulse_cnt++;

    i2c_dtr_trigger u0 (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mode_master(mode_master), .mode_tx(mode_tx),
        .addr_hit(addr_hit), .ack_ctl(ack_ctl),
        .scl_i(scl_line), .sda_i(sda_line),
        .scl_low(scl_low), .sda_low(sda_low),
        .busy(busy), .byte_done(byte_done), .ack_rx(ack_rx)
    );

    // vector: {is_tx, byte, resp}; resp = ack level from remote (tx) or ack_ctl (rx)
    localparam logic [9:0] VEC [7] = '{
        {1'b1, 8'hA5, 1'b0}, {1'b1, 8'h5A, 1'b1}, {1'b1, 8'h00, 1'b0},
        {1'b1, 8'hFF, 1'b0}, {1'b0, 8'hC3, 1'b0}, {1'b0, 8'h81, 1'b1},
        {1'b0, 8'h7E, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1;
        host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1;
        d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // remote receiver for a master transmit
    task automatic resp_tx(input logic ack_lvl, output logic [7:0] cap);
        cap = 8'h00;
        for (int i = 0; i < 8; i++) begin
            @(posedge scl_line);
            cap = {cap[6:0], sda_line};
        end
        @(negedge scl_line);
        #1 tb_sda_low = ~ack_lvl;
        @(posedge scl_line);
        @(negedge scl_line);
        #1 tb_sda_low = 1'b0;
    endtask

    // remote transmitter for a master receive
    task automatic resp_rx(input logic [7:0] b, output logic ack_seen);
        tb_sda_low = ~b[7];
        for (int i = 6; i >= 0; i--) begin
            @(posedge scl_line);
            @(negedge scl_line);
            #1 tb_sda_low = ~b[i];
        end
        @(posedge scl_line);
        @(negedge scl_line);
        #1 tb_sda_low = 1'b0;
        @(posedge scl_line);
        ack_seen = sda_line;
        @(negedge scl_line);
    endtask

    // one remote clock pulse in slave mode
    task automatic slave_pulse(input logic pull_sda, output logic seen);
        repeat (10) @(negedge clk);
        tb_sda_low = pull_sda;
        repeat (10) @(negedge clk);
        tb_scl_low = 1'b0;
        repeat (10) @(negedge clk);
        seen = sda_line;
        repeat (10) @(negedge clk);
        tb_scl_low = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [7:0] cap, rd;
        logic ack_seen, seen;
        int d0, p0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(host_rdata == 8'h00, "R1 data register", host_rdata, 8'h00);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(byte_done == 1'b0, "R1 byte_done", byte_done, 0);
        chk(scl_low == 1'b0, "R1 scl released", scl_low, 0);
        chk(sda_low == 1'b0, "R1 sda released", sda_low, 0);

        mode_master = 1'b1;
        repeat (5) @(negedge clk);
        chk(scl_line == 1'b0, "R11 idle master holds scl", scl_line, 0);

        // vector table walk
        for (int v = 0; v < 7; v++) begin
            logic vt, vr;
            logic [7:0] vb;
            {vt, vb, vr} = VEC[v];
            d0 = done_cnt;
            p0 = pulse_cnt;
            if (vt) begin
                mode_tx = 1'b1;
                fork
                    begin
                        host_write(vb);
                        chk(busy == 1'b1, "R2 busy after write", busy, 1);
                        wait_idle();
                    end
                    resp_tx(vr, cap);
                join
                @(negedge clk);
                chk(cap == vb, "R3 byte on wire msb first", cap, vb);
                chk(ack_rx == vr, "R8 ack sampled", ack_rx, vr);
                chk(done_cnt - d0 == 1, "R10 one done pulse", done_cnt - d0, 1);
                chk(pulse_cnt - p0 == 9, "R11 nine scl pulses", pulse_cnt - p0, 9);
                chk(host_rdata == vb, "R2 register loaded", host_rdata, vb);
            end else begin
                mode_tx = 1'b0;
                ack_ctl = vr;
                fork
                    begin
                        host_read(rd);
                        chk(busy == 1'b1, "R4 busy after read", busy, 1);
                        wait_idle();
                    end
                    resp_rx(vb, ack_seen);
                join
                @(negedge clk);
                chk(ack_seen == vr, "R7 ack driven per ack_ctl", ack_seen, vr);
                chk(done_cnt - d0 == 1, "R10 one done pulse", done_cnt - d0, 1);
                mode_tx = 1'b1;
                p0 = pulse_cnt;
                host_read(rd);
                chk(rd == vb, "R4 received byte", rd, vb);
                repeat (30) @(negedge clk);
                chk(busy == 1'b0, "R5 read after mode switch no start", busy, 0);
                chk(pulse_cnt == p0, "R5 no scl pulse", pulse_cnt - p0, 0);
                chk(scl_line == 1'b0, "R11 scl parked low", scl_line, 0);
            end
        end

        // R9: write during a byte and write in the byte_done cycle are ignored
        mode_tx = 1'b1;
        fork
            begin
                host_write(8'h3C);
                repeat (3) @(negedge clk);
                host_wr = 1'b1;
                host_wdata = 8'hFF;
                @(negedge clk);
                host_wr = 1'b0;
                while (!byte_done) @(negedge clk);
                host_wr = 1'b1;
                host_wdata = 8'h77;
                @(negedge clk);
                host_wr = 1'b0;
            end
            resp_tx(1'b0, cap);
        join
        p0 = pulse_cnt;
        repeat (40) @(negedge clk);
        chk(cap == 8'h3C, "R9 mid-byte write ignored on wire", cap, 8'h3C);
        chk(host_rdata == 8'h3C, "R9 register kept", host_rdata, 8'h3C);
        chk(busy == 1'b0, "R9 done-cycle write starts nothing", busy, 0);
        chk(pulse_cnt == p0, "R9 no extra scl pulse", pulse_cnt - p0, 0);

        // slave mode
        tb_scl_low = 1'b1;
        mode_master = 1'b0;
        addr_hit = 1'b0;
        repeat (5) @(negedge clk);
        chk(scl_low == 1'b0, "R11 slave releases scl", scl_low, 0);
        d0 = done_cnt;
        host_write(8'h99);
        chk(busy == 1'b0, "R6 unaddressed write no start", busy, 0);
        cap = 8'h00;
        for (int i = 0; i < 9; i++) begin
            slave_pulse(1'b0, seen);
            cap = {cap[6:0], seen};
        end
        chk(cap == 8'hFF, "R6 sda untouched when unaddressed", cap, 8'hFF);
        chk(done_cnt == d0, "R6 no done when unaddressed", done_cnt - d0, 0);

        addr_hit = 1'b1;
        host_write(8'h96);
        chk(busy == 1'b1, "R6 addressed write starts", busy, 1);
        cap = 8'h00;
        for (int i = 0; i < 8; i++) begin
            slave_pulse(1'b0, seen);
            cap = {cap[6:0], seen};
        end
        slave_pulse(1'b1, seen);
        repeat (10) @(negedge clk);
        tb_sda_low = 1'b0;
        chk(cap == 8'h96, "R6 slave byte on wire", cap, 8'h96);
        chk(ack_rx == 1'b0, "R8 slave ack seen", ack_rx, 0);
        chk(busy == 1'b0, "R9 busy clears after byte", busy, 0);
        chk(done_cnt - d0 == 1, "R10 slave done once", done_cnt - d0, 1);

        finish_run();
    end

endmodule